// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block sits behind a two-wire serial front end and owns the storage side of a small serial EEPROM. The front end hands it one strobe per decoded event: a byte address, a data byte, a read of one byte, or a STOP condition. Data bytes are gathered into a 16-byte staging buffer that belongs to one 16-byte page of the active 256-byte bank. A STOP after at least one accepted data byte starts a timed internal write cycle. At its end only the buffer positions that were actually loaded are copied into a behavioural memory array.

A single address pointer serves both directions. A byte address loads it. Each accepted data byte moves the in-page position forward, wrapping inside the page. Each byte read moves the whole offset forward, wrapping inside the active bank. A read that arrives without a new byte address continues from wherever the pointer stands. A write-protect pin and a block-permission input are checked at the first data byte of a transaction. If either forbids the write, that byte and the rest of the transaction are refused and nothing is stored. While the write cycle runs, the block reports busy and ignores every strobe.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy and data_ack are 0, the pointer is offset 0x00 and every byte of both banks reads 0xFF.
- R2: Data bytes following a byte address A are stored, after STOP and the write cycle, at A, A+1, ... within the page selected by bits [7:4] of A. Bits [3:0] give the starting position.
- R3: The in-page position (bits [3:0] of the pointer) advances after every accepted data byte and wraps from 15 to 0 without changing bits [7:4]. More than 16 bytes therefore overwrite earlier bytes of the same transaction.
- R4: Only positions loaded in the transaction are changed by the write cycle. The other bytes of the page keep their contents.
- R5: Nothing is committed without a STOP. A new byte address or a read before the STOP discards the loaded bytes, and a later STOP then starts no write cycle.
- R6: A STOP that ends a transaction holding at least one accepted byte raises busy on the next clock. Busy stays high for exactly WR_CYCLES clocks. While busy, address, data, read and STOP strobes have no effect.
- R7: Each read strobe returns the byte at the active bank and pointer on rd_data one clock later and advances the pointer by one. It wraps from 0xFF to 0x00 of the same bank.
- R8: After a write cycle the pointer holds the offset following the last loaded byte, wrapped within the page. A read with no new byte address starts there.
- R9: wp_pin and blk_open are sampled only at the first data byte after a byte address. If wp_pin is 1 or blk_open is 0 there, that byte and all later bytes of the transaction get data_ack 0 and nothing is written. A change of wp_pin after the first byte has no effect.
- R10: Writes land in the bank selected by bank_sel when the byte address arrived. Reads use the bank selected by bank_sel at the read strobe.
- R11: data_ack is 1 for one clock, one clock after each accepted data byte, and is never 1 without a data strobe on the clock before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Byte address strobe |
| addr_in | input | 8 | Byte address within the bank |
| data_we | input | 1 | Data byte strobe |
| data_in | input | 8 | Data byte |
| rd_req | input | 1 | Read one byte strobe |
| stop_evt | input | 1 | STOP condition seen on the bus |
| bank_sel | input | 1 | Active bank (0 lower, 1 upper) |
| blk_open | input | 1 | 1 when software protection allows writing the addressed block |
| wp_pin | input | 1 | Write-protect pin, 1 protects the whole memory |
| rd_data | output | 8 | Byte returned by the last read strobe |
| data_ack | output | 1 | Acceptance pulse for a data byte |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions watch, on every clock, the exact length of the busy window and that it opens only after a STOP. They also check the one-step pointer advance on reads and that data bytes never move the pointer out of its page. Two further checks cover the refusal of a first byte under write protection and that acceptance pulses only follow data strobes. The bench scenarios cover what only memory contents can reveal. These are the byte placement after in-page wrap, preserved neighbours in a partial page, loss of data without a STOP, bank steering, the sampling point of the protect inputs, and the pointer position a write leaves behind.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int PW_DATA_W     = 8;
    localparam int PW_BANK_BYTES = 256;
    localparam int PW_PAGE_BYTES = 16;
    localparam int PW_BANKS      = 2;
    localparam int PW_WR_CYCLES  = 200;

    // one strobe is acted on per clock; this is the decoded event
    typedef enum logic [2:0] {
        EV_NONE,
        EV_ADDR,
        EV_DATA,
        EV_READ,
        EV_STOP
    } pw_event_e;

    function automatic pw_event_e pw_decode(input logic busy, input logic a,
                                            input logic d, input logic r,
                                            input logic s);
        if (busy)   return EV_NONE;
        else if (a) return EV_ADDR;
        else if (d) return EV_DATA;
        else if (r) return EV_READ;
        else if (s) return EV_STOP;
        else        return EV_NONE;
    endfunction

endpackage

// File: rtl/pw_buffer.sv
module pw_buffer #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int POS_W     = $clog2(PAGE_BYTES)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 clr,
    input  logic                                 wr,
    input  logic [POS_W-1:0]                     idx,
    input  logic [DATA_W-1:0]                    din,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]    bytes_q,
    output logic [PAGE_BYTES-1:0]                mask_q
);

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                mask_q[g]  <= 1'b0;
                bytes_q[g] <= '0;
            end else if (wr && idx == POS_W'(g)) begin
                mask_q[g]  <= 1'b1;
                bytes_q[g] <= din;
            end
        end
    end

endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
    parameter int WR_CYCLES = 200,
    localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    logic [CNT_W-1:0] remain;

    assign done = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CNT_W'(WR_CYCLES - 1);
        end
    end

endmodule

// File: rtl/pw_array.sv
module pw_array #(
    parameter int DATA_W     = 8,
    parameter int BANK_BYTES = 256,
    parameter int PAGE_BYTES = 16,
    parameter int BANKS      = 2,
    localparam int ADDR_W    = $clog2(BANK_BYTES),
    localparam int POS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - POS_W,
    localparam int BANK_W    = $clog2(BANKS),
    localparam int DEPTH     = BANKS * BANK_BYTES
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              commit,
    input  logic [BANK_W-1:0]                 cbank,
    input  logic [PAGE_W-1:0]                 cpage,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0] cdata,
    input  logic [PAGE_BYTES-1:0]             cmask,
    input  logic [BANK_W-1:0]                 rbank,
    input  logic [ADDR_W-1:0]                 raddr,
    output logic [DATA_W-1:0]                 rdata
);

    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    logic [DATA_W-1:0] cells [DEPTH];

    assign rdata = cells[{rbank, raddr}];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (cmask[i]) cells[{cbank, cpage, POS_W'(i)}] <= cdata[i];
        end
    end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import pw_pkg::*;
#(
    parameter int DATA_W     = PW_DATA_W,
    parameter int BANK_BYTES = PW_BANK_BYTES,
    parameter int PAGE_BYTES = PW_PAGE_BYTES,
    parameter int BANKS      = PW_BANKS,
    parameter int WR_CYCLES  = PW_WR_CYCLES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          addr_we,
    input  logic [$clog2(BANK_BYTES)-1:0] addr_in,
    input  logic                          data_we,
    input  logic [DATA_W-1:0]             data_in,
    input  logic                          rd_req,
    input  logic                          stop_evt,
    input  logic [$clog2(BANKS)-1:0]      bank_sel,
    input  logic                          blk_open,
    input  logic                          wp_pin,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          data_ack,
    output logic                          busy
);

    localparam int ADDR_W = $clog2(BANK_BYTES);
    localparam int POS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - POS_W;
    localparam int BANK_W = $clog2(BANKS);

    pw_event_e                       ev;
    logic [ADDR_W-1:0]               ptr;
    logic [BANK_W-1:0]               wbank;
    logic                            txn_open;
    logic                            first_pend;
    logic                            reject;
    logic                            accept;
    logic                            buf_wr;
    logic                            buf_clr;
    logic                            wr_start;
    logic                            wr_done;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_bytes;
    logic [PAGE_BYTES-1:0]           buf_mask;
    logic [DATA_W-1:0]               arr_rdata;

    assign ev       = pw_decode(busy, addr_we, data_we, rd_req, stop_evt);
    // protection is judged once, at the first data byte of the transaction
    assign accept   = first_pend ? (!wp_pin && blk_open) : !reject;
    assign buf_wr   = (ev == EV_DATA) && txn_open && accept;
    assign wr_start = (ev == EV_STOP) && txn_open && (|buf_mask) && !reject;
    assign buf_clr  = (ev == EV_ADDR) || (ev == EV_READ) || wr_done ||
                      ((ev == EV_STOP) && !wr_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            wbank      <= '0;
            txn_open   <= 1'b0;
            first_pend <= 1'b0;
            reject     <= 1'b0;
            data_ack   <= 1'b0;
            rd_data    <= '0;
        end else begin
            data_ack <= 1'b0;
            unique case (ev)
                EV_ADDR: begin
                    ptr        <= addr_in;
                    wbank      <= bank_sel;
                    txn_open   <= 1'b1;
                    first_pend <= 1'b1;
                    reject     <= 1'b0;
                end
                EV_DATA: begin
                    if (txn_open) begin
                        first_pend <= 1'b0;
                        if (accept) begin
                            ptr      <= {ptr[ADDR_W-1:POS_W], ptr[POS_W-1:0] + 1'b1};
                            data_ack <= 1'b1;
                        end else begin
                            reject <= 1'b1;
                        end
                    end
                end
                EV_READ: begin
                    rd_data  <= arr_rdata;
                    ptr      <= ptr + 1'b1;
                    txn_open <= 1'b0;
                end
                EV_STOP: txn_open <= 1'b0;
                default: ;
            endcase
        end
    end

    pw_buffer #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (buf_clr),
        .wr      (buf_wr),
        .idx     (ptr[POS_W-1:0]),
        .din     (data_in),
        .bytes_q (buf_bytes),
        .mask_q  (buf_mask)
    );

    pw_timer #(
        .WR_CYCLES (WR_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (wr_start),
        .busy  (busy),
        .done  (wr_done)
    );

    pw_array #(
        .DATA_W     (DATA_W),
        .BANK_BYTES (BANK_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .BANKS      (BANKS)
    ) u_arr (
        .clk    (clk),
        .rst    (rst),
        .commit (wr_done),
        .cbank  (wbank),
        .cpage  (ptr[ADDR_W-1:POS_W]),
        .cdata  (buf_bytes),
        .cmask  (buf_mask),
        .rbank  (bank_sel),
        .raddr  (ptr),
        .rdata  (arr_rdata)
    );

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int WR_CYCLES = 200,
    parameter int ADDR_W    = 8,
    parameter int POS_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_we,
    input logic              data_we,
    input logic              rd_req,
    input logic              stop_evt,
    input logic              wp_pin,
    input logic              busy,
    input logic              data_ack,
    input logic              txn_open,
    input logic              first_pend,
    input logic [ADDR_W-1:0] ptr
);

    int busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= 0;
        else              busy_run <= busy_run + 1;
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == WR_CYCLES);

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_evt));

    // R7
    rd_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !busy && !addr_we && !data_we) |=> ptr == $past(ptr) + 1'b1);

    // R3
    in_page_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we && !addr_we && !busy) |=> ptr[ADDR_W-1:POS_W] == $past(ptr[ADDR_W-1:POS_W]));

    // R9
    wp_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we && !addr_we && !busy && txn_open && first_pend && wp_pin) |=> !data_ack);

    // R11
    ack_src_chk: assert property (@(posedge clk) disable iff (rst)
        data_ack |-> $past(data_we));

endmodule

bind eeprom_page_writer pw_checker #(
    .WR_CYCLES (WR_CYCLES),
    .ADDR_W    (ADDR_W),
    .POS_W     (POS_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_we    (addr_we),
    .data_we    (data_we),
    .rd_req     (rd_req),
    .stop_evt   (stop_evt),
    .wp_pin     (wp_pin),
    .busy       (busy),
    .data_ack   (data_ack),
    .txn_open   (txn_open),
    .first_pend (first_pend),
    .ptr        (ptr)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;

    localparam int WR = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_we = 0, data_we = 0, rd_req = 0, stop_evt = 0;
    logic [7:0] addr_in = 0, data_in = 0;
    logic       bank_sel = 0, blk_open = 1, wp_pin = 0;
    logic [7:0] rd_data;
    logic       data_ack, busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    eeprom_page_writer #(.WR_CYCLES(WR)) dut (
        .clk(clk), .rst(rst), .addr_we(addr_we), .addr_in(addr_in),
        .data_we(data_we), .data_in(data_in), .rd_req(rd_req),
        .stop_evt(stop_evt), .bank_sel(bank_sel), .blk_open(blk_open),
        .wp_pin(wp_pin), .rd_data(rd_data), .data_ack(data_ack), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_addr(input logic [7:0] a);
        addr_we = 1; addr_in = a;
        @(negedge clk); addr_we = 0;
    endtask

    task automatic do_data(input logic [7:0] d, output logic ack);
        data_we = 1; data_in = d;
        @(negedge clk); data_we = 0;
        ack = data_ack;
    endtask

    task automatic do_stop();
        stop_evt = 1;
        @(negedge clk); stop_evt = 0;
    endtask

    task automatic do_read(output logic [7:0] d);
        rd_req = 1;
        @(negedge clk); rd_req = 0;
        d = rd_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 busy", busy, 0);
        chk("R1 data_ack", data_ack, 0);
        do_read(d); chk("R1 erased byte at 0x00", d, 8'hFF);
        bank_sel = 1; do_read(d); chk("R1 erased upper bank", d, 8'hFF); bank_sel = 0;
    endtask

    task automatic t_page_write();
        logic ack; logic [7:0] d; int n;
        do_addr(8'h25);
        do_data(8'hA1, ack); chk("R11 ack first", ack, 1);
        do_data(8'hA2, ack);
        do_data(8'hA3, ack); chk("R11 ack third", ack, 1);
        do_stop();
        chk("R6 busy after STOP", busy, 1);
        wait_idle(n);
        chk("R6 busy length", n, WR);
        do_addr(8'h24);
        do_read(d); chk("R4 byte before run", d, 8'hFF);
        do_read(d); chk("R2 byte 0x25", d, 8'hA1);
        do_read(d); chk("R2 byte 0x26", d, 8'hA2);
        do_read(d); chk("R2 byte 0x27", d, 8'hA3);
        do_read(d); chk("R4 byte after run", d, 8'hFF);
    endtask

    task automatic t_wrap();
        logic ack; logic [7:0] d; int n;
        do_addr(8'h3E);
        for (int k = 0; k < 18; k++) do_data(8'h80 + 8'(k), ack);
        do_stop(); wait_idle(n);
        // pointer now at 0x30: immediate read walks the page
        for (int p = 0; p < 16; p++) begin
            int e;
            e = (p < 14) ? 8'h80 + p + 2 : 8'h80 + p + 2;
            if (p == 14) e = 8'h80 + 16;
            if (p == 15) e = 8'h80 + 17;
            do_read(d);
            chk(p == 0 ? "R8 read resumes after last byte" : "R3 in-page wrap overwrite", d, e);
        end
    endtask

    task automatic t_partial();
        logic ack; logic [7:0] d; int n;
        do_addr(8'h25); do_data(8'h55, ack); do_stop(); wait_idle(n);
        do_addr(8'h25);
        do_read(d); chk("R4 rewritten byte", d, 8'h55);
        do_read(d); chk("R4 neighbour kept", d, 8'hA2);
    endtask

    task automatic t_no_stop();
        logic ack; logic [7:0] d;
        do_addr(8'h50); do_data(8'h77, ack);
        do_addr(8'h50); do_read(d); chk("R5 no commit before STOP", d, 8'hFF);
        do_stop(); @(negedge clk);
        chk("R5 late STOP starts nothing", busy, 0);
    endtask

    task automatic t_busy_ignored();
        logic ack; logic [7:0] d; int n;
        do_addr(8'h60); do_data(8'h11, ack); do_stop();
        do_addr(8'h70); do_data(8'h99, ack); do_stop();
        chk("R6 data strobe ignored while busy", ack, 0);
        wait_idle(n); @(negedge clk);
        chk("R6 STOP while busy ignored", busy, 0);
        do_addr(8'h70); do_read(d); chk("R6 address+data ignored while busy", d, 8'hFF);
        do_addr(8'h60); do_read(d); chk("R6 earlier write kept", d, 8'h11);
    endtask

    task automatic t_protect();
        logic ack; logic [7:0] d; int n;
        wp_pin = 1;
        do_addr(8'h80); do_data(8'h42, ack); chk("R9 wp refuses first byte", ack, 0);
        do_data(8'h43, ack); chk("R9 later byte refused", ack, 0);
        do_stop(); @(negedge clk); chk("R9 no write cycle", busy, 0);
        wp_pin = 0;
        do_addr(8'h80); do_read(d); chk("R9 protected byte unchanged", d, 8'hFF);
        blk_open = 0;
        do_addr(8'hA0); do_data(8'h31, ack); chk("R9 block closed refuses", ack, 0);
        do_stop(); blk_open = 1;
        do_addr(8'hA0); do_read(d); chk("R9 closed block unchanged", d, 8'hFF);
        do_addr(8'h90); do_data(8'hB1, ack);
        wp_pin = 1;
        do_data(8'hB2, ack); chk("R9 wp after first byte ignored", ack, 1);
        do_stop(); wait_idle(n); wp_pin = 0;
        do_addr(8'h90);
        do_read(d); chk("R9 first byte stored", d, 8'hB1);
        do_read(d); chk("R9 second byte stored", d, 8'hB2);
    endtask

    task automatic t_bank();
        logic ack; logic [7:0] d; int n;
        bank_sel = 1;
        do_addr(8'h25); do_data(8'hC3, ack);
        bank_sel = 0;  // bank taken at address time
        do_stop(); wait_idle(n);
        do_addr(8'h25); do_read(d); chk("R10 lower bank untouched", d, 8'h55);
        bank_sel = 1;
        do_addr(8'h25); do_read(d); chk("R10 upper bank written", d, 8'hC3);
        bank_sel = 0;
    endtask

    task automatic t_seq_wrap();
        logic ack; logic [7:0] d; int n;
        do_addr(8'hFF); do_data(8'hEE, ack); do_stop(); wait_idle(n);
        do_addr(8'h00); do_data(8'hDD, ack); do_stop(); wait_idle(n);
        do_addr(8'hFF);
        do_read(d); chk("R7 last byte of bank", d, 8'hEE);
        do_read(d); chk("R7 wrap to 0x00 same bank", d, 8'hDD);
        do_read(d); chk("R7 advance to 0x01", d, 8'hFF);
        bank_sel = 1;
        do_addr(8'hFF);
        do_read(d); chk("R7 upper bank 0xFF", d, 8'hFF);
        do_read(d); chk("R7 upper bank wraps in itself", d, 8'hFF);
        bank_sel = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_page_write();
        t_wrap();
        t_partial();
        t_no_stop();
        t_busy_ignored();
        t_protect();
        t_bank();
        t_seq_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule